// File: doc/BRIEF.md
# Cache-Line-Multiple Burst Size Selector

This block decides how long the next write burst of a bus master should be while that master works through a long block move. The move is loaded with a start address and a byte count. The block keeps the current address and the bytes still to go. On each request strobe it returns a burst length one clock later. It also returns a flag that marks whether the burst may be issued with the cache-line-granular write command. When the bus side reports how many bytes a burst actually moved, the block advances the address and reduces the count by that amount.

A qualifying burst is always a whole number of cache lines. It is the largest such number that fits both the data still to go and the programmed ceiling. Because the choice is made again before every burst, bursts step down toward single lines as the move nears its end. An unaligned start, or a tail shorter than a line, gets a plain burst that is not flagged. That burst is sized to reach the next line boundary or the end of the data.

Top module: `clmult_burst_sel`

## Requirements
- R1: After reset, `sel_valid_o`, `sel_bytes_o`, `sel_line_cmd_o`, `rem_bytes_o` and `cur_addr_o` are all zero. A result is presented with `sel_valid_o` high exactly one clock after a cycle with `req_i` high. `sel_valid_o` is low one clock after a cycle with `req_i` low.
- R2: The line size in bytes is 4 << (`cfg_line_code_i` - 1); code 0 turns the cache-line command off. The programmed ceiling in bytes is 8 << {`cfg_burst_ext_i`, `cfg_burst_field_i`}, with the extension bit as the most significant bit of that 3-bit exponent.
- R3: When the address is line-aligned and at least one line remains, the flag is 1. The burst is the largest multiple of the line that is no larger than the remaining bytes and no larger than the effective ceiling. The effective ceiling is the larger of the programmed ceiling and one line.
- R4: When the programmed ceiling is not larger than one line, every flagged burst is exactly one line.
- R5: When the line size is nonzero and the address is not line-aligned, the flag is 0. The burst is the smaller of the remaining bytes and the distance to the next line boundary.
- R6: When the address is line-aligned but fewer bytes than one line remain (and more than zero), the flag is 0 and the burst equals the remaining bytes.
- R7: When the line size code is 0, the flag is 0 and the burst is the smaller of the remaining bytes and the programmed ceiling.
- R8: When no bytes remain, the burst is 0 and the flag is 0.
- R9: `start_i` loads the address and count. `xfer_i` adds `xfer_bytes_i` to the address and subtracts it from the count, and the count saturates at 0. When `start_i` and `xfer_i` are high together, the load wins.
- R10: When `req_i` and `xfer_i` are high in the same cycle, the result is computed from the address and count held before that cycle's update.
- R11: Requesting repeatedly and transferring each returned burst in full drains a move completely. The flagged bursts never grow from one burst to the next, and the move ends with the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_line_code_i | input | 3 | Cache line size code (0 = off) |
| cfg_burst_field_i | input | 2 | Low bits of the burst ceiling exponent |
| cfg_burst_ext_i | input | 1 | Extension bit of the burst ceiling exponent |
| start_i | input | 1 | Load a new move |
| start_addr_i | input | 32 | Start byte address of the move |
| start_bytes_i | input | 16 | Byte count of the move |
| req_i | input | 1 | Request a burst decision |
| xfer_i | input | 1 | A burst finished |
| xfer_bytes_i | input | 16 | Bytes actually moved by that burst |
| sel_valid_o | output | 1 | Decision presented this cycle |
| sel_bytes_o | output | 16 | Chosen burst length in bytes |
| sel_line_cmd_o | output | 1 | Burst qualifies for the cache-line write command |
| rem_bytes_o | output | 16 | Bytes still to transfer |
| cur_addr_o | output | 32 | Current byte address |

## Verification
A decision request and a completed-transfer update can land on the same clock edge. This is the main collision. The bench provokes it by raising `req_i` and `xfer_i` together on an aligned move. It then checks that the returned length and flag belong to the old address and count, while the tracked address and count already show the update. A second request right after that must see the now unaligned address. A separate check raises `start_i` and `xfer_i` together to show that the load wins. All other decisions are swept over line codes 0 to 4, every ceiling code, a range of address offsets and a set of counts, and each result is compared against an arithmetic model.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned CNT_W      = 16;
  localparam int unsigned LCODE_W    = 3;
  localparam int unsigned BFIELD_W   = 2;
  localparam int unsigned BCODE_W    = BFIELD_W + 1;

  typedef struct packed {
    logic [CNT_W-1:0] bytes;
    logic             line_cmd;
  } choice_t;
endpackage

// File: rtl/bsel_rst_sync.sv
module bsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_sync_n = s1_q;
endmodule

// File: rtl/bsel_geometry.sv
module bsel_geometry #(
  parameter int unsigned CW  = 16,
  parameter int unsigned LW  = 3,
  parameter int unsigned BFW = 2
) (
  input  logic [LW-1:0]  line_code,
  input  logic [BFW-1:0] burst_field,
  input  logic           burst_ext,
  output logic [CW-1:0]  line_bytes,
  output logic [CW-1:0]  ceil_bytes
);
  localparam int unsigned BCW = BFW + 1;
  logic [BCW-1:0] bcode;
  logic [LW-1:0]  lshift;

  always_comb begin
    bcode  = {burst_ext, burst_field};
    lshift = line_code - LW'(1);
    if (line_code == '0) line_bytes = '0;
    else                 line_bytes = CW'(4) << lshift;
    ceil_bytes = CW'(8) << bcode;
  end
endmodule

// File: rtl/bsel_tracker.sv
module bsel_tracker #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] start_bytes,
  input  logic          xfer,
  input  logic [CW-1:0] xfer_bytes,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] rem_q
);
  logic [AW-1:0] addr_d;
  logic [CW-1:0] rem_d;
  logic          upd_en;

  always_comb begin
    upd_en = start | xfer;
    addr_d = addr_q;
    rem_d  = rem_q;
    if (start) begin
      addr_d = start_addr;
      rem_d  = start_bytes;
    end else if (xfer) begin
      addr_d = addr_q + AW'(xfer_bytes);
      rem_d  = (xfer_bytes >= rem_q) ? '0 : rem_q - xfer_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  // R9: without a load the count never grows
  p_rem_no_grow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> rem_q <= $past(rem_q));

  // R9: idle cycles leave the address alone
  p_addr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !xfer) |=> $stable(addr_q));
endmodule

// File: rtl/bsel_chooser.sv
module bsel_chooser #(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0]      addr_lo,
  input  logic [CW-1:0]      rem,
  input  logic [CW-1:0]      line_bytes,
  input  logic [CW-1:0]      ceil_bytes,
  output bsel_pkg::choice_t  pick
);
  logic [CW-1:0] eff_ceil, lim, off, to_bnd, lmask;

  always_comb begin
    lmask    = line_bytes - CW'(1);
    eff_ceil = (ceil_bytes > line_bytes) ? ceil_bytes : line_bytes;
    lim      = (rem < eff_ceil) ? rem : eff_ceil;
    off      = addr_lo & lmask;
    to_bnd   = line_bytes - off;
    pick.bytes    = '0;
    pick.line_cmd = 1'b0;
    if (rem == '0) begin
      pick.bytes = '0;
    end else if (line_bytes == '0) begin
      pick.bytes = (rem < ceil_bytes) ? rem : ceil_bytes;
    end else if (off != '0) begin
      pick.bytes = (rem < to_bnd) ? rem : to_bnd;
    end else if (rem < line_bytes) begin
      pick.bytes = rem;
    end else begin
      pick.bytes    = lim & ~lmask;
      pick.line_cmd = 1'b1;
    end
  end
endmodule

// File: rtl/clmult_burst_sel.sv
module clmult_burst_sel #(
  parameter int unsigned AW  = bsel_pkg::ADDR_W,
  parameter int unsigned CW  = bsel_pkg::CNT_W,
  parameter int unsigned LW  = bsel_pkg::LCODE_W,
  parameter int unsigned BFW = bsel_pkg::BFIELD_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LW-1:0]  cfg_line_code_i,
  input  logic [BFW-1:0] cfg_burst_field_i,
  input  logic           cfg_burst_ext_i,
  input  logic           start_i,
  input  logic [AW-1:0]  start_addr_i,
  input  logic [CW-1:0]  start_bytes_i,
  input  logic           req_i,
  input  logic           xfer_i,
  input  logic [CW-1:0]  xfer_bytes_i,
  output logic           sel_valid_o,
  output logic [CW-1:0]  sel_bytes_o,
  output logic           sel_line_cmd_o,
  output logic [CW-1:0]  rem_bytes_o,
  output logic [AW-1:0]  cur_addr_o
);
  import bsel_pkg::*;

  logic          rst_sync_n;
  logic [CW-1:0] line_bytes, ceil_bytes;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q;
  choice_t       pick, pick_q, pick_d;
  logic          valid_q;

  bsel_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  bsel_geometry #(.CW(CW), .LW(LW), .BFW(BFW)) u_geo (
    .line_code(cfg_line_code_i), .burst_field(cfg_burst_field_i),
    .burst_ext(cfg_burst_ext_i), .line_bytes(line_bytes), .ceil_bytes(ceil_bytes));

  bsel_tracker #(.AW(AW), .CW(CW)) u_trk (
    .clk(clk), .rst_n(rst_sync_n), .start(start_i), .start_addr(start_addr_i),
    .start_bytes(start_bytes_i), .xfer(xfer_i), .xfer_bytes(xfer_bytes_i),
    .addr_q(addr_q), .rem_q(rem_q));

  bsel_chooser #(.CW(CW)) u_cho (
    .addr_lo(addr_q[CW-1:0]), .rem(rem_q), .line_bytes(line_bytes),
    .ceil_bytes(ceil_bytes), .pick(pick));

  always_comb begin
    pick_d = req_i ? pick : pick_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      pick_q  <= '0;
    end else begin
      valid_q <= req_i;
      pick_q  <= pick_d;
    end
  end

  assign sel_valid_o    = valid_q;
  assign sel_bytes_o    = pick_q.bytes;
  assign sel_line_cmd_o = pick_q.line_cmd;
  assign rem_bytes_o    = rem_q;
  assign cur_addr_o     = addr_q;

  // R1: a decision follows every request by one clock
  p_valid_after_req_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_i |=> sel_valid_o);
  p_valid_quiet_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_i |=> !sel_valid_o);
  // R3: a burst never exceeds the bytes still to go
  p_cap_rem_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pick.bytes <= rem_q);
  // R3: a flagged burst is a whole number of lines from an aligned address
  p_flag_lines_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pick.line_cmd |-> (line_bytes != '0) && ((pick.bytes & (line_bytes - CW'(1))) == '0)
                      && ((addr_q[CW-1:0] & (line_bytes - CW'(1))) == '0));
  // R8: nothing left means an empty, unflagged decision
  p_empty_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rem_q == '0) |-> (pick.bytes == '0) && !pick.line_cmd);
  // R5: data left always yields progress
  p_progress_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rem_q != '0) |-> (pick.bytes != '0));
endmodule

// File: tb/clmult_burst_sel_test.sv
module clmult_burst_sel_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  line_code;
  logic [1:0]  bfield;
  logic        bext;
  logic        start, req, xfer;
  logic [31:0] start_addr;
  logic [15:0] start_bytes, xfer_bytes;
  logic        sel_valid, sel_line_cmd;
  logic [15:0] sel_bytes, rem_bytes;
  logic [31:0] cur_addr;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  clmult_burst_sel uut (
    .clk(clk), .rst_n(rst_n), .cfg_line_code_i(line_code),
    .cfg_burst_field_i(bfield), .cfg_burst_ext_i(bext), .start_i(start),
    .start_addr_i(start_addr), .start_bytes_i(start_bytes), .req_i(req),
    .xfer_i(xfer), .xfer_bytes_i(xfer_bytes), .sel_valid_o(sel_valid),
    .sel_bytes_o(sel_bytes), .sel_line_cmd_o(sel_line_cmd),
    .rem_bytes_o(rem_bytes), .cur_addr_o(cur_addr));

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(int addr, int rem, int lc, int bc,
                                output int bytes, output int flag);
    int line, cap, off, m;
    line = (lc == 0) ? 0 : (4 << (lc - 1));
    cap  = 8 << bc;
    flag = 0;
    if (rem == 0) bytes = 0;
    else if (line == 0) bytes = (rem < cap) ? rem : cap;
    else begin
      off = addr % line;
      if (off != 0) bytes = (rem < line - off) ? rem : line - off;
      else if (rem < line) bytes = rem;
      else begin
        m = (cap > line) ? cap : line;
        if (rem < m) m = rem;
        bytes = (m / line) * line;
        flag = 1;
      end
    end
  endfunction

  task automatic set_cfg(int lc, int bc);
    line_code = 3'(lc);
    bext      = bc[2];
    bfield    = bc[1:0];
  endtask

  task automatic load(int addr, int nbytes);
    @(negedge clk);
    start = 1'b1; start_addr = addr; start_bytes = 16'(nbytes);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic ask(string tag, int exp_b, int exp_f);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check({tag, " valid"}, sel_valid, 1);
    check({tag, " bytes"}, sel_bytes, exp_b);
    check({tag, " flag"}, sel_line_cmd, exp_f);
  endtask

  initial begin
    int rems[10] = '{0, 4, 12, 16, 32, 60, 64, 100, 256, 1000};
    int eb, ef, a, r, prev;
    rst_n = 1'b0; start = 0; req = 0; xfer = 0;
    start_addr = 0; start_bytes = 0; xfer_bytes = 0;
    set_cfg(3, 2);
    repeat (3) @(negedge clk);
    check("R1 reset valid", sel_valid, 0);
    check("R1 reset bytes", sel_bytes, 0);
    check("R1 reset flag", sel_line_cmd, 0);
    check("R1 reset rem", rem_bytes, 0);
    check("R1 reset addr", cur_addr, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2..R8 sweep; the idle cycle of each load checks valid low (R1)
    for (int lc = 0; lc <= 4; lc++)
      for (int bc = 0; bc <= 7; bc++)
        for (int off = 0; off <= 16; off += 4)
          for (int k = 0; k < 10; k++) begin
            set_cfg(lc, bc);
            load(32'h400 + off, rems[k]);
            check("R1 idle valid", sel_valid, 0);
            model(32'h400 + off, rems[k], lc, bc, eb, ef);
            ask("R2-sweep", eb, ef);
          end

    // R4: ceiling at or below one line gives single lines
    set_cfg(4, 0); load(32'h800, 200); ask("R4 cap8 line32", 32, 1);
    set_cfg(3, 1); load(32'h800, 200); ask("R4 cap16 line16", 16, 1);
    // R3: largest multiple, not a power of two
    set_cfg(2, 5); load(32'h800, 100); ask("R3 multiple", 96, 1);
    // R5, R6, R7, R8 spot points
    set_cfg(3, 3); load(32'h804, 100); ask("R5 to boundary", 12, 0);
    load(32'h800, 9); ask("R6 short tail", 9, 0);
    set_cfg(0, 2); load(32'h804, 100); ask("R7 line off", 32, 0);
    set_cfg(3, 3); load(32'h800, 0); ask("R8 empty", 0, 0);

    // R9: update, saturation, load priority
    load(32'h1000, 100);
    @(negedge clk); xfer = 1; xfer_bytes = 40;
    @(negedge clk); xfer = 0;
    check("R9 rem after xfer", rem_bytes, 60);
    check("R9 addr after xfer", cur_addr, 32'h1028);
    xfer = 1; xfer_bytes = 500;
    @(negedge clk); xfer = 0;
    check("R9 rem saturates", rem_bytes, 0);
    start = 1; start_addr = 32'h2000; start_bytes = 77; xfer = 1; xfer_bytes = 10;
    @(negedge clk); start = 0; xfer = 0;
    check("R9 load wins rem", rem_bytes, 77);
    check("R9 load wins addr", cur_addr, 32'h2000);

    // R10: request and transfer together see the old state
    set_cfg(3, 2); load(32'h200, 100);
    req = 1; xfer = 1; xfer_bytes = 20;
    @(negedge clk); req = 0; xfer = 0;
    check("R10 old bytes", sel_bytes, 32);
    check("R10 old flag", sel_line_cmd, 1);
    check("R10 rem updated", rem_bytes, 80);
    check("R10 addr updated", cur_addr, 32'h214);
    ask("R10 next sees new", 12, 0);

    // R11: drain a move burst by burst
    set_cfg(3, 3); load(32'h1008, 190);
    a = 32'h1008; r = 190; prev = 1 << 30;
    for (int n = 0; n < 20 && r > 0; n++) begin
      model(a, r, 3, 3, eb, ef);
      ask("R11 step", eb, ef);
      if (ef == 1) begin
        check("R11 no growth", (sel_bytes <= prev) ? 1 : 0, 1);
        prev = sel_bytes;
      end
      xfer = 1; xfer_bytes = sel_bytes;
      @(negedge clk); xfer = 0;
      a += eb; r -= eb;
    end
    check("R11 drained", rem_bytes, 0);
    check("R11 end addr", cur_addr, 32'h1008 + 190);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule